// File: doc/BRIEF.md
# Trusted Address Aging Table

This block holds a small table of 32-bit IP addresses that the local side currently trusts. Each slot pairs a content-addressable entry with a one-bit freshness flag at the same index, where 1 means fresh and 0 means stale. When a packet leaves toward an address, the insert port adds that address or refreshes it. The lookup port then tells the receive path whether an arriving source address is trusted.

A free-running counter raises a tick once every `TICK_CYCLES` clock cycles. Each tick starts a sweep that visits the slots one per cycle in ascending index order. A fresh slot is demoted to stale and keeps its address. A stale slot is deleted. An address is therefore trusted for between one and two sweep periods after its last outgoing packet. No per-entry countdown is kept.

Top module: `trust_age_top`

## Requirements
- R1: A synchronous active-high reset empties every slot, clears every freshness flag, returns the sweep to idle and drives `lk_hit` and `full` to 0.
- R2: An insert of an address not in the table writes it into the lowest-index empty slot with its flag set to fresh. A lookup of that address from the next cycle on reports a hit.
- R3: An insert of an address already in the table only sets that slot's flag to fresh. It takes no second slot.
- R4: `lk_hit` is registered. It is 1 in the cycle after a lookup request exactly when a valid slot holds the requested address, and it is 0 after any cycle without a request.
- R5: The tick fires at the clock edge where the counter has seen `TICK_CYCLES` cycles since reset or since the previous tick, so the first tick falls on the `TICK_CYCLES`-th edge after reset is released. The sweep then handles slot i on edge k*`TICK_CYCLES`+1+i, one slot per cycle in index order.
- R6: The sweep rewrites a fresh slot's flag to stale and leaves its address trusted.
- R7: The sweep deletes a stale slot, after which its address is no longer trusted.
- R8: A lookup made in the same cycle that the sweep deletes the matching slot reports a miss.
- R9: When an insert and the sweep touch the same slot in the same cycle, the insert wins. The slot stays valid with its flag fresh.
- R10: `full` is 1 while every slot is valid. An insert of a new address while the table is full is dropped, and later lookups of that address miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ins_valid | input | 1 | Outgoing-packet insert request |
| ins_addr | input | 32 | Destination address to trust or refresh |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Source address to check |
| lk_hit | output | 1 | Registered result: the address is trusted |
| full | output | 1 | Every slot is occupied |

## Verification
The bench counts clock edges from the release of reset and places each insert and lookup on an exact edge relative to the sweep schedule. A lookup timed to the very cycle a stale slot is deleted catches a design that reads the table before applying the deletion, because such a design reports a stale hit. An insert timed onto the slot the sweep is deleting catches a design that gives the sweep priority, because that design loses the refreshed address one period early. Refilling the table after deletions and then watching which slot ages first catches a wrong free-slot choice and a wrong sweep order. A duplicate insert into a full table, followed by an insert of a new address, catches a design that allocates twice or that overwrites a slot when the table is full.

// File: rtl/trust_age_pkg.sv
package trust_age_pkg;

    localparam int IP_W = 32;

    typedef logic [IP_W-1:0] ip_t;

    typedef enum logic {
        SW_IDLE = 1'b0,
        SW_RUN  = 1'b1
    } sweep_state_e;

    typedef struct packed {
        logic valid;
        ip_t  addr;
    } addr_req_t;

endpackage

// File: rtl/age_tick_gen.sv
module age_tick_gen #(
    parameter int TICK_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/age_sweep_seq.sv
module age_sweep_seq
    import trust_age_pkg::*;
#(
    parameter int SLOTS = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tick,
    output logic                       busy,
    output logic [$clog2(SLOTS)-1:0]   idx
);
    localparam int IDX_W = $clog2(SLOTS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

    sweep_state_e state_q;
    logic [IDX_W-1:0] idx_q;

    assign busy = (state_q == SW_RUN);
    assign idx  = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SW_IDLE;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                SW_IDLE: begin
                    if (tick) begin
                        state_q <= SW_RUN;
                        idx_q   <= '0;
                    end
                end
                SW_RUN: begin
                    if (idx_q == LAST) begin
                        state_q <= SW_IDLE;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= SW_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/trust_table.sv
module trust_table
    import trust_age_pkg::*;
#(
    parameter int SLOTS = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  addr_req_t                 ins,
    input  addr_req_t                 lk,
    input  logic                      sw_busy,
    input  logic [$clog2(SLOTS)-1:0]  sw_idx,
    output logic                      lk_hit,
    output logic                      full,
    output logic [SLOTS-1:0]          slot_valid,
    output logic [SLOTS-1:0]          slot_fresh,
    output logic                      ins_match_any
);
    localparam int IDX_W = $clog2(SLOTS);

    ip_t              cam_q [SLOTS];
    logic [SLOTS-1:0] valid_q, fresh_q;
    logic [SLOTS-1:0] ins_match, ins_touch, sw_del, sw_dem, lk_match;
    logic [IDX_W-1:0] free_idx;
    logic             has_free;
    logic             lk_hit_q;

    // lowest-index empty slot
    always_comb begin
        free_idx = '0;
        has_free = 1'b0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                free_idx = IDX_W'(i);
                has_free = 1'b1;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            ins_match[i] = valid_q[i] && (cam_q[i] == ins.addr);
        end
    end

    assign ins_match_any = |ins_match;

    // per-slot actions; an insert masks the sweep on its slot
    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            ins_touch[i] = ins.valid &&
                           (ins_match[i] ||
                            (!ins_match_any && has_free && free_idx == IDX_W'(i)));
            sw_del[i]   = sw_busy && (sw_idx == IDX_W'(i)) && valid_q[i] &&
                          !fresh_q[i] && !ins_touch[i];
            sw_dem[i]   = sw_busy && (sw_idx == IDX_W'(i)) && valid_q[i] &&
                          fresh_q[i] && !ins_touch[i];
            lk_match[i] = valid_q[i] && (cam_q[i] == lk.addr) && !sw_del[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= '0;
            fresh_q  <= '0;
            lk_hit_q <= 1'b0;
        end else begin
            lk_hit_q <= lk.valid && (|lk_match);
            for (int i = 0; i < SLOTS; i++) begin
                if (ins_touch[i]) begin
                    valid_q[i] <= 1'b1;
                    fresh_q[i] <= 1'b1;
                    cam_q[i]   <= ins.addr;
                end else if (sw_del[i]) begin
                    valid_q[i] <= 1'b0;
                    fresh_q[i] <= 1'b0;
                end else if (sw_dem[i]) begin
                    fresh_q[i] <= 1'b0;
                end
            end
        end
    end

    assign lk_hit     = lk_hit_q;
    assign full       = &valid_q;
    assign slot_valid = valid_q;
    assign slot_fresh = fresh_q;
endmodule

// File: rtl/trust_age_top.sv
module trust_age_top
    import trust_age_pkg::*;
#(
    parameter int SLOTS       = 8,
    parameter int TICK_CYCLES = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ins_valid,
    input  logic [IP_W-1:0] ins_addr,
    input  logic            lk_valid,
    input  logic [IP_W-1:0] lk_addr,
    output logic            lk_hit,
    output logic            full
);
    localparam int IDX_W = $clog2(SLOTS);

    addr_req_t        ins_req, lk_req;
    logic             tick;
    logic             sw_busy;
    logic [IDX_W-1:0] sw_idx;
    logic [SLOTS-1:0] slot_valid, slot_fresh;
    logic             ins_match_any;

    assign ins_req = '{valid: ins_valid, addr: ins_addr};
    assign lk_req  = '{valid: lk_valid,  addr: lk_addr};

    age_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    age_sweep_seq #(.SLOTS(SLOTS)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .busy (sw_busy),
        .idx  (sw_idx)
    );

    trust_table #(.SLOTS(SLOTS)) u_tbl (
        .clk           (clk),
        .rst           (rst),
        .ins           (ins_req),
        .lk            (lk_req),
        .sw_busy       (sw_busy),
        .sw_idx        (sw_idx),
        .lk_hit        (lk_hit),
        .full          (full),
        .slot_valid    (slot_valid),
        .slot_fresh    (slot_fresh),
        .ins_match_any (ins_match_any)
    );
endmodule

// File: rtl/trust_age_chk.sv
module trust_age_chk #(
    parameter int SLOTS = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     lk_valid,
    input logic                     lk_hit,
    input logic                     full,
    input logic                     ins_valid,
    input logic                     ins_match_any,
    input logic [SLOTS-1:0]         slot_valid,
    input logic [SLOTS-1:0]         slot_fresh,
    input logic                     busy,
    input logic [$clog2(SLOTS)-1:0] idx
);
    localparam int IDX_W = $clog2(SLOTS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (slot_valid == '0 && slot_fresh == '0 && !busy && !lk_hit));

    // R4
    lk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !lk_hit);

    // R3
    dup_no_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && ins_match_any && !busy) |=>
        ($countones(slot_valid) == $countones($past(slot_valid))));

    // R5
    sweep_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && idx != LAST) |=> (busy && idx == $past(idx) + 1'b1));

    // R6
    fresh_subset_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_fresh & ~slot_valid) == '0);

    // R7
    only_sweep_frees_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ($countones(slot_valid) >= $countones($past(slot_valid))));

    // R10
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (full && !busy) |=> full);
endmodule

bind trust_age_top trust_age_chk #(.SLOTS(SLOTS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .lk_valid      (lk_valid),
    .lk_hit        (lk_hit),
    .full          (full),
    .ins_valid     (ins_valid),
    .ins_match_any (ins_match_any),
    .slot_valid    (slot_valid),
    .slot_fresh    (slot_fresh),
    .busy          (sw_busy),
    .idx           (sw_idx)
);

// File: tb/sim_trust_age_top.sv
`timescale 1ns/1ps
module sim_trust_age_top;
    localparam int SLOTS = 8;
    localparam int T     = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ins_valid = 1'b0;
    logic [31:0] ins_addr  = '0;
    logic        lk_valid  = 1'b0;
    logic [31:0] lk_addr   = '0;
    logic        lk_hit, full;

    int checks = 0;
    int errors = 0;
    int edge_n = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    trust_age_top #(.SLOTS(SLOTS), .TICK_CYCLES(T)) u0 (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_addr(ins_addr),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_hit(lk_hit), .full(full)
    );

    // edges counted since reset release
    always @(posedge clk) begin
        if (rst) edge_n <= 0;
        else     edge_n <= edge_n + 1;
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b (edge %0d)", tag, act, exp, edge_n);
        end
    endtask

    task automatic goto(input int n);
        while (edge_n < n - 1) @(negedge clk);
    endtask

    task automatic ins_at(input int n, input logic [31:0] a);
        goto(n);
        ins_valid = 1'b1;
        ins_addr  = a;
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic lk_at(input int n, input logic [31:0] a, input logic exp, input string tag);
        goto(n);
        lk_valid = 1'b1;
        lk_addr  = a;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(tag, lk_hit, exp);
    endtask

    task automatic reset_dut();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    localparam logic [31:0] A = 32'h0A00_0001;
    localparam logic [31:0] B = 32'h0A00_0002;
    localparam logic [31:0] C = 32'hC0A8_0101;
    localparam logic [31:0] D = 32'h0A00_0004;
    localparam logic [31:0] E = 32'hDEAD_BEEF;
    localparam logic [31:0] F = 32'h0B00_0001;
    localparam logic [31:0] G = 32'h0B00_0002;
    localparam logic [31:0] H = 32'h0C00_0001;

    initial begin
        @(negedge clk);
        reset_dut();
        // R1 reset state
        chk("R1 lk_hit after reset", lk_hit, 1'b0);
        chk("R1 full after reset", full, 1'b0);

        ins_at(2, A);                 // slot 0
        ins_at(3, B);                 // slot 1
        ins_at(4, A);                 // duplicate
        lk_at(5, A, 1'b1, "R2 new address trusted");
        @(negedge clk);
        chk("R4 lk_hit drops without request", lk_hit, 1'b0);
        lk_at(7, C, 1'b0, "R4 unknown address misses");

        // sweep 1 at edges 65..72 demotes A,B
        ins_at(80, B);                // refresh B
        lk_at(81, A, 1'b1, "R6 stale address still trusted");

        // sweep 2: slot0 (A, stale) deleted at edge 129
        lk_at(2*T + 1, A, 1'b0, "R8 lookup in deletion cycle misses");
        lk_at(140, B, 1'b1, "R6 refreshed B demoted but kept");
        lk_at(141, A, 1'b0, "R7 stale A deleted");

        ins_at(150, D);               // lowest free slot: 0
        // sweep 3: slot1 (B, stale) touched at edge 194, collide
        ins_at(3*T + 2, B);
        // sweep 4: slot0 D deleted at 257, slot1 B demoted at 258
        lk_at(270, B, 1'b1, "R9 insert beats sweep deletion");
        lk_at(271, D, 1'b0, "R7 D deleted after two sweeps");

        // fill slots 0,2..7
        for (int k = 0; k < 7; k++) ins_at(280 + k, 32'h1000_0000 + k);
        chk("R10 full when all slots valid", full, 1'b1);
        ins_at(288, E);
        lk_at(289, E, 1'b0, "R10 insert dropped when full");
        ins_at(290, B);               // duplicate while full
        lk_at(291, 32'h1000_0006, 1'b1, "R3 dup insert keeps other entries");
        chk("R3 still full after duplicate", full, 1'b1);

        goto(340);
        chk("R6 full after demote-only sweep", full, 1'b1);
        // sweep 6 at 385..392 deletes everything
        goto(400);
        chk("R7 table empty after second sweep", full, 1'b0);
        lk_at(400, 32'h1000_0003, 1'b0, "R7 filled entry expired");

        ins_at(402, F);               // slot 0
        ins_at(403, G);               // slot 1
        // sweep 8: F deleted at 513, G at 514
        lk_at(8*T + 1, G, 1'b1, "R5 slot1 not yet swept at edge 513");
        lk_at(8*T + 2, F, 1'b0, "R5 slot0 deleted first");
        lk_at(520, G, 1'b0, "R5 slot1 deleted next");

        ins_at(530, H);
        lk_at(531, H, 1'b1, "R2 H trusted before reset");
        reset_dut();
        lk_at(2, H, 1'b0, "R1 reset clears table");
        chk("R1 full cleared", full, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule